// File: doc/BRIEF.md
# Rotated Gray-Code Hypercube Path Sequencer

This block walks a hypercube of dimension `DIM` one link at a time. After a start pulse it presents node address 0, and each accepted step moves it to the next entry of the binary reflected Gray code. The sequence has 2^DIM entries, visits every node exactly once, and changes exactly one address bit per step. A path index, captured at start, selects one of `DIM` variants. In variant p, every code word is rotated left circularly by p bit positions. Running the variants side by side gives orderings that use different hypercube dimensions on each step, so all links can carry traffic at the same time.

Alongside the address, the block gives a one-hot vector that names the dimension link crossed on the step just taken, a busy indication, and a flag that marks the final entry of the tour. After that final entry the block goes back to idle on its own. Moving the payload over the links is left to the surrounding logic.

Top module: `gray_path_seq`

## Requirements
- R1: While reset is asserted, and on its release, `busy_o`, `last_o`, `flip_o` and `addr_o` are all zero.
- R2: A `start_i` high in an idle cycle makes `busy_o` 1 on the next clock. On that clock `addr_o` is 0 (tour entry 0) and `flip_o` is 0.
- R3: When `step_i` is high in a busy cycle that is not flagged last, the step count k rises by one. One clock later, `addr_o` equals (k XOR (k>>1)) rotated left by the captured path index. For path 0 and DIM=3, the tour is 000, 001, 011, 010, 110, 111, 101, 100.
- R4: In the cycle after an accepted step, `flip_o` has exactly one bit set, and it equals the XOR of the new and previous `addr_o`. In every other cycle `flip_o` is 0.
- R5: The path index p is sampled with the start pulse and rotates each word left by p. An index of DIM or more is reduced by DIM (so for DIM=5, index 6 acts as 1).
- R6: `last_o` is 1 exactly in the cycle in which `addr_o` shows entry 2^DIM−1. That address differs from entry 0 in one bit.
- R7: In the clock after `last_o`, `busy_o` returns to 0 and `addr_o` holds the final entry, even if `step_i` is high.
- R8: `step_i` while idle has no effect: `busy_o` and `flip_o` stay 0 and `addr_o` holds.
- R9: `start_i` while busy is ignored. The tour continues with the same count and the same path index.
- R10: With `step_i` low in a busy cycle, `addr_o` holds and `flip_o` is 0.
- R11: One complete tour presents every one of the 2^DIM addresses exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a tour (accepted only when idle) |
| path_i | input | $clog2(DIM) | Rotation (path) index, sampled with start |
| step_i | input | 1 | Advance one entry while busy |
| busy_o | output | 1 | A tour is in progress |
| addr_o | output | DIM | Current node address |
| flip_o | output | DIM | One-hot dimension crossed on the last step |
| last_o | output | 1 | Current address is the final tour entry |

## Verification
Every output comes from registers updated on the rising edge that samples `start_i` or `step_i`. The new address, its one-hot link vector and the last flag are therefore due exactly one clock after the stimulus, and the return to idle follows one clock after `last_o`. The bench drives inputs just after a falling edge and compares every output against a behavioural model on the next falling edge, which is half a period after the edge that took the stimulus. Directed checks on path entries, rotation folding, ignored starts and the idle transition use that same one-clock offset.

// File: rtl/gray_path_pkg.sv
package gray_path_pkg;

    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_RUN  = 2'd1,
        WALK_LAST = 2'd2
    } walk_state_e;

endpackage

// File: rtl/gp_binary_to_gray.sv
module gp_binary_to_gray #(
    parameter int W = 5
) (
    input  logic [W-1:0] bin_i,
    output logic [W-1:0] gray_o
);
    // Reflected code word for a linear index
    assign gray_o = bin_i ^ (bin_i >> 1);
endmodule

// File: rtl/gp_lowest_set.sv
module gp_lowest_set #(
    parameter int W = 5
) (
    input  logic [W-1:0] bin_i,
    output logic [W-1:0] onehot_o
);
    // Going from k-1 to k in the reflected code flips the bit at k's lowest one
    assign onehot_o = bin_i & (~bin_i + W'(1));
endmodule

// File: rtl/gp_rotate_left.sv
module gp_rotate_left #(
    parameter int W  = 5,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    output logic [W-1:0]  data_o
);
    logic [W-1:0] opt [W];

    for (genvar s = 0; s < W; s++) begin : g_rot
        logic [2*W-1:0] dbl;
        assign dbl    = {data_i, data_i} << s;
        assign opt[s] = dbl[2*W-1:W];
    end

    always_comb begin
        data_o = opt[0];
        for (int s = 1; s < W; s++) begin
            if (amt_i == SW'(s)) begin
                data_o = opt[s];
            end
        end
    end
endmodule

// File: rtl/gp_walk_ctrl.sv
module gp_walk_ctrl
    import gray_path_pkg::*;
#(
    parameter int DIM = 5,
    parameter int PW  = $clog2(DIM)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [PW-1:0] path_i,
    input  logic          step_i,
    output walk_state_e   state_o,
    output logic [DIM-1:0] cnt_o,
    output logic [PW-1:0] path_o,
    output logic          stepped_o
);
    localparam int unsigned   ENTRIES = 1 << DIM;
    localparam logic [DIM-1:0] PENULT = DIM'(ENTRIES - 2);
    localparam logic [PW:0]   DIM_W   = (PW+1)'(DIM);

    typedef struct packed {
        walk_state_e    state;
        logic [DIM-1:0] cnt;
        logic [PW-1:0]  path;
        logic           stepped;
    } walk_t;

    walk_t cur_q, nxt_d;
    logic [PW-1:0] path_fold;

    always_comb begin
        if ({1'b0, path_i} >= DIM_W) begin
            path_fold = path_i - DIM_W[PW-1:0];
        end else begin
            path_fold = path_i;
        end
    end

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.stepped = 1'b0;
        unique case (cur_q.state)
            WALK_IDLE: begin
                if (start_i) begin
                    nxt_d.state = WALK_RUN;
                    nxt_d.cnt   = '0;
                    nxt_d.path  = path_fold;
                end
            end
            WALK_RUN: begin
                if (step_i) begin
                    nxt_d.cnt     = cur_q.cnt + DIM'(1);
                    nxt_d.stepped = 1'b1;
                    if (cur_q.cnt == PENULT) begin
                        nxt_d.state = WALK_LAST;
                    end
                end
            end
            WALK_LAST: begin
                nxt_d.state = WALK_IDLE;
            end
            default: begin
                nxt_d.state = WALK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '{WALK_IDLE, '0, '0, 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_o   = cur_q.state;
    assign cnt_o     = cur_q.cnt;
    assign path_o    = cur_q.path;
    assign stepped_o = cur_q.stepped;
endmodule

// File: rtl/gray_path_seq.sv
module gray_path_seq
    import gray_path_pkg::*;
#(
    parameter int DIM = 5,
    localparam int PW = $clog2(DIM)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           start_i,
    input  logic [PW-1:0]  path_i,
    input  logic           step_i,
    output logic           busy_o,
    output logic [DIM-1:0] addr_o,
    output logic [DIM-1:0] flip_o,
    output logic           last_o
);
    walk_state_e    state_q;
    logic [DIM-1:0] cnt_q;
    logic [PW-1:0]  path_q;
    logic           stepped_q;
    logic [DIM-1:0] gray_w;
    logic [DIM-1:0] low_w;
    logic [DIM-1:0] flip_rot;

    gp_walk_ctrl #(.DIM(DIM), .PW(PW)) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .path_i    (path_i),
        .step_i    (step_i),
        .state_o   (state_q),
        .cnt_o     (cnt_q),
        .path_o    (path_q),
        .stepped_o (stepped_q)
    );

    gp_binary_to_gray #(.W(DIM)) u_gray (
        .bin_i  (cnt_q),
        .gray_o (gray_w)
    );

    gp_rotate_left #(.W(DIM), .SW(PW)) u_rot_addr (
        .data_i (gray_w),
        .amt_i  (path_q),
        .data_o (addr_o)
    );

    gp_lowest_set #(.W(DIM)) u_low (
        .bin_i    (cnt_q),
        .onehot_o (low_w)
    );

    gp_rotate_left #(.W(DIM), .SW(PW)) u_rot_flip (
        .data_i (low_w),
        .amt_i  (path_q),
        .data_o (flip_rot)
    );

    assign flip_o = stepped_q ? flip_rot : '0;
    assign busy_o = (state_q != WALK_IDLE);
    assign last_o = (state_q == WALK_LAST);
endmodule

// File: rtl/gray_path_seq_chk.sv
module gray_path_seq_chk #(
    parameter int DIM = 5
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           start_i,
    input logic           step_i,
    input logic           busy_o,
    input logic [DIM-1:0] addr_o,
    input logic [DIM-1:0] flip_o,
    input logic           last_o
);
    // R2: an accepted start presents entry 0 with no link flagged
    p_start_origin_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> (busy_o && addr_o == '0 && flip_o == '0));

    // R4: an accepted step changes exactly the flagged bit
    p_flip_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !last_o && step_i) |=>
            ($countones(flip_o) == 1 && flip_o == (addr_o ^ $past(addr_o))));

    // R10: no step, no movement
    p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !last_o && !step_i) |=> ($stable(addr_o) && flip_o == '0));

    // R8: step while idle leaves everything alone
    p_idle_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !start_i) |=> (!busy_o && $stable(addr_o) && flip_o == '0));

    // R6: final entry is one link away from entry 0 and only while busy
    p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_o |-> (busy_o && $countones(addr_o) == 1));

    // R7: the tour ends the clock after the last flag
    p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_o |=> (!busy_o && !last_o && $stable(addr_o)));
endmodule

bind gray_path_seq gray_path_seq_chk #(.DIM(DIM)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .step_i  (step_i),
    .busy_o  (busy_o),
    .addr_o  (addr_o),
    .flip_o  (flip_o),
    .last_o  (last_o)
);

// File: tb/gray_path_seq_test.sv
`timescale 1ns/1ps
module gray_path_seq_test;
    localparam int D  = 5;
    localparam int N  = 1 << D;
    localparam int PW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [PW-1:0] path_i = '0;
    logic          step_i = 1'b0;
    logic          busy_o, last_o;
    logic [D-1:0]  addr_o, flip_o;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;
    int wd = 0;

    // behavioural reference state
    bit m_busy, m_last;
    int m_cnt, m_path, m_addr, m_flip;

    always #2.5 clk = ~clk;

    gray_path_seq #(.DIM(D)) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .path_i(path_i),
        .step_i(step_i), .busy_o(busy_o), .addr_o(addr_o), .flip_o(flip_o),
        .last_o(last_o)
    );

    function automatic int refl(input int k);
        return k ^ (k >> 1);
    endfunction

    function automatic int rotl(input int v, input int p);
        int r = 0;
        for (int b = 0; b < D; b++)
            if (((v >> b) & 1) != 0) r |= 1 << ((b + p) % D);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_last = 0; m_cnt = 0; m_path = 0; m_addr = 0; m_flip = 0;
        end else if (m_last) begin
            m_busy = 0; m_last = 0; m_flip = 0;
        end else if (m_busy) begin
            if (step_i) begin
                int na;
                m_cnt++;
                na = rotl(refl(m_cnt), m_path);
                m_flip = na ^ m_addr;
                m_addr = na;
                m_last = (m_cnt == N - 1);
            end else begin
                m_flip = 0;
            end
        end else begin
            m_flip = 0;
            if (start_i) begin
                m_busy = 1; m_cnt = 0; m_addr = 0;
                m_path = (int'(path_i) >= D) ? int'(path_i) - D : int'(path_i);
            end
        end
    end

    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk(busy_o == m_busy, "R2 busy", int'(busy_o), int'(m_busy));
            chk(int'(addr_o) == m_addr, "R3 addr", int'(addr_o), m_addr);
            chk(int'(flip_o) == m_flip, "R4 flip", int'(flip_o), m_flip);
            chk(last_o == m_last, "R6 last", int'(last_o), int'(m_last));
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // drive inputs just after a falling edge, return at the next falling edge
    task automatic cyc(input bit st, input bit sp, input int p);
        start_i = st; step_i = sp; path_i = PW'(p);
        @(negedge clk);
    endtask

    initial begin
        int seq0 [8] = '{0, 1, 3, 2, 6, 7, 5, 4};
        bit seen [N];
        int guard;

        @(negedge clk);
        // R1 during reset
        chk(busy_o == 0 && last_o == 0, "R1 flags", int'(busy_o), 0);
        chk(addr_o == '0 && flip_o == '0, "R1 addr/flip", int'(addr_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        chk(busy_o == 0 && addr_o == '0, "R1 after release", int'(addr_o), 0);

        // R8: steps while idle
        repeat (3) cyc(0, 1, 0);
        chk(busy_o == 0 && addr_o == '0 && flip_o == '0, "R8 idle step", int'(addr_o), 0);

        // path 0 tour with a pause
        foreach (seen[i]) seen[i] = 0;
        cyc(1, 0, 0);
        chk(busy_o == 1 && addr_o == '0 && flip_o == '0, "R2 origin", int'(addr_o), 0);
        seen[addr_o] = 1;
        for (int i = 1; i < 8; i++) begin
            cyc(0, 1, 0);
            chk(int'(addr_o) == seq0[i], "R3 path0 entry", int'(addr_o), seq0[i]);
            seen[addr_o] = 1;
            if (i == 4) begin
                cyc(0, 0, 0);
                chk(int'(addr_o) == seq0[4] && flip_o == '0, "R10 pause hold",
                    int'(addr_o), seq0[4]);
            end
        end
        guard = 0;
        while (!last_o && guard < 40) begin
            cyc(0, 1, 0);
            if (!seen[addr_o]) seen[addr_o] = 1;
            else chk(0, "R11 revisit", int'(addr_o), -1);
            guard++;
        end
        chk(last_o == 1 && int'(addr_o) == 16, "R6 last entry path0", int'(addr_o), 16);
        begin
            int nseen = 0;
            foreach (seen[i]) nseen += seen[i];
            chk(nseen == N, "R11 coverage", nseen, N);
        end
        cyc(0, 1, 0);
        chk(busy_o == 0 && int'(addr_o) == 16, "R7 release hold", int'(addr_o), 16);
        cyc(0, 1, 0);
        chk(busy_o == 0 && int'(addr_o) == 16 && flip_o == '0, "R8 idle after tour",
            int'(addr_o), 16);

        // path index 6 folds to 1; start while busy ignored
        cyc(1, 0, 6);
        cyc(0, 1, 0);
        chk(int'(addr_o) == 2, "R5 fold 6->1 first step", int'(addr_o), 2);
        cyc(1, 1, 2);
        chk(int'(addr_o) == rotl(refl(2), 1) && busy_o, "R9 start ignored",
            int'(addr_o), rotl(refl(2), 1));
        cyc(1, 0, 3);
        chk(int'(addr_o) == rotl(refl(2), 1), "R9 no restart", int'(addr_o), rotl(refl(2), 1));
        guard = 0;
        while (!last_o && guard < 40) begin cyc(0, 1, 0); guard++; end
        chk(int'(addr_o) == rotl(16, 1), "R6 last entry path1", int'(addr_o), rotl(16, 1));
        cyc(0, 0, 0);

        // path 3 with continuous stepping
        cyc(1, 0, 3);
        cyc(0, 1, 0);
        chk(int'(addr_o) == 8 && int'(flip_o) == 8, "R5 rotate by 3", int'(addr_o), 8);
        guard = 0;
        while (!last_o && guard < 40) begin cyc(0, 1, 0); guard++; end
        chk(int'(addr_o) == 4, "R6 last entry path3", int'(addr_o), 4);
        cyc(0, 1, 0);
        chk(busy_o == 0, "R7 idle path3", int'(busy_o), 0);

        // path 4 (largest unfolded index)
        cyc(1, 0, 4);
        cyc(0, 1, 0);
        chk(int'(addr_o) == 16 && $countones(flip_o) == 1, "R5 rotate by 4", int'(addr_o), 16);
        repeat (3) cyc(0, 1, 0);

        model_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule